// File: doc/BRIEF.md
# AUX Line Deglitch and Timebase

This block prepares a single-bit serial auxiliary line for a decoder that runs on the host bus clock. The raw line passes through a two-flop synchronizer. A stability filter then lets a new level through only after the line has held it for a programmed number of clocks. Shorter glitches never reach the output, and the output keeps the last level it accepted.

The same block produces the timebase for the channel. An integer divider turns the host clock into a 1 MHz tick; software sets the divider to the clock rate in MHz. Inside each divider period the block also raises three one-cycle sample strobes. The early strobe sits at three eighths of the period, the middle strobe at one half and the late strobe at five eighths. A downstream decoder uses these strobes to sample half-bit cells.

The filter code selects the stable-clock count. Software picks the largest legal code whose count, times the clock period, stays within 0.4 µs.

Top module: `aux_line_conditioner`

## Requirements
- R1: While reset is held, `line_o` is 1 and `tick_o`, `early_o`, `mid_o` and `late_o` are 0.
- R2: With divider value D (D=0 behaves as D=1), `tick_o` is high after the n-th rising edge since reset release exactly when n>0 and n mod D = 0. It is high for one cycle per period.
- R3: `early_o` is high after rising edge n (n≥1) exactly when (n-1) mod D = floor(D/8)*3.
- R4: `late_o` is high after rising edge n (n≥1) exactly when (n-1) mod D = floor(D/8)*5.
- R5: `mid_o` is high after rising edge n (n≥1) exactly when (n-1) mod D = floor(D/2).
- R6: The filter code maps to a stable count N as follows: 0→7, 8→7, 16→15, 24→23, 32→31, 40→40, 48→47.
- R7: Any filter code outside {0,8,16,24,32,40,48} gives N=7.
- R8: `line_o` takes a new level only after the synchronized line has differed from `line_o` for N consecutive clocks. A pulse on `line_in` that lasts fewer than N clocks has no effect on `line_o`.
- R9: When `line_in` changes just before a rising edge and then holds for at least N clocks, `line_o` takes the new level after the (N+2)-th rising edge counted from that edge. It does not change before that edge.
- R10: A return of the synchronized line to the level of `line_o` restarts the stability count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw asynchronous auxiliary line |
| div_i | input | 8 | Host clock cycles per 1 MHz tick |
| filt_code_i | input | 8 | Stability filter code |
| line_o | output | 1 | Filtered line level |
| tick_o | output | 1 | 1 MHz tick, one cycle wide |
| early_o | output | 1 | Sample strobe at 3/8 of the period |
| mid_o | output | 1 | Sample strobe at 1/2 of the period |
| late_o | output | 1 | Sample strobe at 5/8 of the period |

## Verification
The assertions assume that the divider and filter code change only while reset is held, or stay stable across the cycles being checked. The strobe-spacing and single-cycle-tick properties are guarded with a stability condition on the divider for this reason. The stimulus follows the same rule: every random configuration is loaded during reset. Each configuration then runs with random hold lengths on the raw line, chosen to straddle the filter count, together with directed pulses one clock short of N, exactly N, and interrupted runs.

// File: rtl/aux_cond_pkg.sv
package aux_cond_pkg;
  localparam int FILT_CODE_W = 8;
  localparam int FILT_CNT_W  = 6;

  typedef logic [FILT_CNT_W-1:0] filt_cnt_t;

  // Stable-clock count required for each legal filter code; others fall back to 7.
  function automatic filt_cnt_t filt_limit(input logic [FILT_CODE_W-1:0] code);
    case (code)
      8'd16:   filt_limit = filt_cnt_t'(15);
      8'd24:   filt_limit = filt_cnt_t'(23);
      8'd32:   filt_limit = filt_cnt_t'(31);
      8'd40:   filt_limit = filt_cnt_t'(40);
      8'd48:   filt_limit = filt_cnt_t'(47);
      default: filt_limit = filt_cnt_t'(7);
    endcase
  endfunction
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) shreg_q <= {STAGES{RESET_VAL}};
    else     shreg_q <= {shreg_q[STAGES-2:0], d_i};
  end

  assign q_o = shreg_q[STAGES-1];
endmodule

// File: rtl/aux_deglitch.sv
module aux_deglitch
  import aux_cond_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FILT_CODE_W-1:0] code_i,
  input  logic                   sync_i,
  output logic                   line_o
);
  filt_cnt_t limit;
  filt_cnt_t cnt_q;
  logic      line_q;

  assign limit = filt_limit(code_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_i == line_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= limit - filt_cnt_t'(1)) begin
      line_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + filt_cnt_t'(1);
    end
  end

  assign line_o = line_q;

  // R8
  line_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q != $past(line_q)) |-> ($past(sync_i) == line_q));

  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_i == line_q) |=> (cnt_q == '0));
endmodule

// File: rtl/aux_timebase.sv
module aux_timebase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             early_o,
  output logic             mid_o,
  output logic             late_o
);
  localparam int NUM_PTS = 3;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] eighth;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] pts [NUM_PTS];
  logic [NUM_PTS-1:0] stb_q;
  logic             tick_q;
  logic             wrap;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign eighth  = div_eff >> 3;
  assign pts[0]  = eighth + (eighth << 1);
  assign pts[1]  = div_eff >> 1;
  assign pts[2]  = eighth + (eighth << 2);
  assign wrap    = (cnt_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + DIV_W'(1);
      tick_q <= wrap;
    end
  end

  for (genvar g = 0; g < NUM_PTS; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb_q[g] <= 1'b0;
      else     stb_q[g] <= (cnt_q == pts[g]);
    end
  end

  assign tick_o  = tick_q;
  assign early_o = stb_q[0];
  assign mid_o   = stb_q[1];
  assign late_o  = stb_q[2];

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_q && (div_i > DIV_W'(1)) && $stable(div_i)) |=> !tick_q);

  // R3
  early_late_apart_chk: assert property (@(posedge clk) disable iff (rst)
    ((div_i >= DIV_W'(8)) && $stable(div_i)) |-> !(stb_q[0] && stb_q[2]));
endmodule

// File: rtl/aux_line_conditioner.sv
module aux_line_conditioner
  import aux_cond_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   line_in,
  input  logic [DIV_W-1:0]       div_i,
  input  logic [FILT_CODE_W-1:0] filt_code_i,
  output logic                   line_o,
  output logic                   tick_o,
  output logic                   early_o,
  output logic                   mid_o,
  output logic                   late_o
);
  logic line_sync;

  aux_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (line_in),
    .q_o (line_sync)
  );

  aux_deglitch u_deglitch (
    .clk    (clk),
    .rst    (rst),
    .code_i (filt_code_i),
    .sync_i (line_sync),
    .line_o (line_o)
  );

  aux_timebase #(.DIV_W(DIV_W)) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .div_i   (div_i),
    .tick_o  (tick_o),
    .early_o (early_o),
    .mid_o   (mid_o),
    .late_o  (late_o)
  );

  // R5
  mid_tick_apart_chk: assert property (@(posedge clk) disable iff (rst)
    ((div_i >= 8'd4) && $stable(div_i)) |-> !(mid_o && tick_o));
endmodule

// File: tb/test_aux_line_conditioner.sv
module test_aux_line_conditioner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b1;
  logic [7:0] div_i = 8'd10;
  logic [7:0] filt_code_i = 8'd0;
  logic       line_o, tick_o, early_o, mid_o, late_o;

  int compared = 0;
  int mismatched = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  aux_line_conditioner i_aux_line_conditioner (
    .clk(clk), .rst(rst), .line_in(line_in), .div_i(div_i),
    .filt_code_i(filt_code_i), .line_o(line_o), .tick_o(tick_o),
    .early_o(early_o), .mid_o(mid_o), .late_o(late_o)
  );

  function automatic int need_n(input logic [7:0] c);
    case (c)
      8'd0, 8'd8: return 7;
      8'd16: return 15;
      8'd24: return 23;
      8'd32: return 31;
      8'd40: return 40;
      8'd48: return 47;
      default: return 7;
    endcase
  endfunction

  function automatic int eff_div(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  // Reference model built from the requirements
  logic m_r1, m_r2, m_line;
  int   m_run, n_edges;
  always @(posedge clk) begin
    if (rst) begin
      m_r1 <= 1'b1; m_r2 <= 1'b1; m_line <= 1'b1; m_run <= 0; n_edges <= 0;
    end else begin
      m_r1 <= line_in;
      m_r2 <= m_r1;
      if (m_r2 == m_line) m_run <= 0;
      else if (m_run + 1 >= need_n(filt_code_i)) begin m_line <= m_r2; m_run <= 0; end
      else m_run <= m_run + 1;
      n_edges <= n_edges + 1;
    end
  end

  always @(negedge clk) begin
    if (checking && !rst) begin
      int d, ph;
      d  = eff_div(div_i);
      ph = (n_edges - 1) % d;
      chk(line_o, m_line, "R8");
      chk(tick_o, (n_edges > 0) && (n_edges % d == 0), "R2");
      chk(early_o, (n_edges > 0) && (ph == (d / 8) * 3), "R3");
      chk(late_o, (n_edges > 0) && (ph == (d / 8) * 5), "R4");
      chk(mid_o, (n_edges > 0) && (ph == d / 2), "R5");
    end
  end

  task automatic do_reset(input logic [7:0] d, input logic [7:0] c);
    rst = 1'b1; line_in = 1'b1; div_i = d; filt_code_i = c;
    repeat (3) @(negedge clk);
    chk(line_o, 1'b1, "R1");
    chk(tick_o | early_o | mid_o | late_o, 1'b0, "R1");
    rst = 1'b0;
  endtask

  task automatic drive(input logic v, input int k);
    line_in = v;
    repeat (k) @(negedge clk);
  endtask

  // Measure filter threshold for a code: pulse N-1 ignored, N accepted (R6/R7)
  task automatic threshold(input logic [7:0] c, input int n, input string req);
    do_reset(8'd20, c);
    @(negedge clk);
    drive(1'b0, n - 1);
    drive(1'b1, n + 6);
    chk(line_o, 1'b1, req);
    drive(1'b0, n);
    drive(1'b1, 3);
    chk(line_o, 1'b0, req);
  endtask

  initial begin
    int codes[7] = '{0, 8, 16, 24, 32, 40, 48};
    int ns[7]    = '{7, 7, 15, 23, 31, 40, 47};
    @(negedge clk);
    do_reset(8'd75, 8'd16);
    checking = 1'b1;
    @(negedge clk);

    // R9: latency of an accepted change with N=15
    line_in = 1'b0;
    repeat (16) @(negedge clk);
    chk(line_o, 1'b1, "R9");
    @(negedge clk);
    chk(line_o, 1'b0, "R9");
    drive(1'b1, 30);

    // R8: pulse of N-1 clocks has no effect
    drive(1'b0, 14);
    drive(1'b1, 25);
    chk(line_o, 1'b1, "R8");

    // R10: interruption restarts count
    drive(1'b0, 10);
    drive(1'b1, 1);
    drive(1'b0, 10);
    drive(1'b1, 25);
    chk(line_o, 1'b1, "R10");

    // R6: every legal code's threshold
    for (int i = 0; i < 7; i++) threshold(codes[i][7:0], ns[i], "R6");
    // R7: illegal codes behave as seven
    threshold(8'd5, 7, "R7");
    threshold(8'd200, 7, "R7");
    threshold(8'd47, 7, "R7");

    // R2: divider zero acts as one
    do_reset(8'd0, 8'd0);
    repeat (20) @(negedge clk);
    do_reset(8'd1, 8'd0);
    repeat (20) @(negedge clk);
    do_reset(8'd2, 8'd0);
    repeat (20) @(negedge clk);

    // Random configurations
    void'($urandom(32'd1234));
    for (int s = 0; s < 14; s++) begin
      logic [7:0] d, c;
      int cyc;
      d = 8'($urandom_range(1, 255));
      if ($urandom_range(0, 3) == 0) c = 8'($urandom_range(0, 255));
      else c = 8'(codes[$urandom_range(0, 6)]);
      do_reset(d, c);
      cyc = 0;
      while (cyc < 2500) begin
        int k;
        k = $urandom_range(1, need_n(c) + 12);
        drive(1'($urandom_range(0, 1)), k);
        cyc += k;
      end
    end

    checking = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule